// File: doc/BRIEF.md
# Debug Mode Control Unit

This unit tracks whether a processor core is running its debug handler, and it owns the debug status and control word. It receives debug exception requests from the core's pipeline and trigger logic: single step, external debug interrupt, instruction breakpoint, the software breakpoint instruction, data store breakpoint and data load breakpoint. It also receives ordinary exception events, imprecise error reports and the return-from-debug instruction. In response it redirects the fetch unit to the debug vector, or back to the saved return PC, and keeps the debug-mode flag that the rest of the core uses to grant privileges.

Ordinary exceptions and software breakpoints that occur while the core is already in debug mode do not leave debug mode. They re-vector to the debug handler and change only the status word and the return PC. Imprecise errors are held back by a hold flag that is set on every entry. The handler can clear that flag once it has saved its context, and any held error then fires at once. The unit also decodes a fixed 2 MiB debug address window into a probe-memory half and a debug-register half. The decode is active only in debug mode. A bypass bit lets individual loads and stores reach the normal memory that the window covers.

Top module: `dbg_mode_ctl`

## Requirements
- R1: After reset the unit is out of debug mode, there is no redirect, no imprecise error fires, both segment outputs are 0, the return PC is 0, and a read of the status word returns only the version field (bits 3:1, default 2).
- R2: Outside debug mode, any asserted bit of `dbg_src` gives `redir_valid`=1 with `redir_pc` equal to the debug vector in that same cycle. From the next cycle `dbg_mode` is 1 and `ret_pc` holds the `exc_pc` of the entry cycle.
- R3: On entry exactly one cause bit is recorded, for the lowest-numbered asserted source. Source bits are 0 single step, 1 external interrupt, 2 instruction breakpoint, 3 software breakpoint, 4 data store breakpoint and 5 data load breakpoint. Cause bit k sits at status bit 4+k.
- R4: On entry the halt (bit 15) and doze (bit 16) inputs are captured, and the exception-code field (bits 14:10) is set to 0.
- R5: In debug mode only `exc_valid` and source bit 3 raise an exception. Either one redirects to the debug vector, loads `ret_pc` from `exc_pc`, clears halt and doze, and keeps `dbg_mode` at 1. `exc_valid` has priority and writes `exc_code` with all cause bits 0. The software breakpoint alone writes code 9 and cause bit 3. All other sources are ignored in debug mode.
- R6: `deret` in debug mode redirects to `ret_pc` in the same cycle, and `dbg_mode` and the hold flag are 0 from the next cycle. An exception in the same cycle takes precedence. `deret` outside debug mode has no effect.
- R7: `soft_rst` clears debug mode, the hold flag, the bypass bit and all pending errors. It produces no redirect.
- R8: Every entry or debug-mode exception sets the hold flag (bit 19). While it is set, `imp_err` bits are recorded as pending at status bits 20..23. The `imp_err` bit order is 0 instruction-fetch bus error, 1 data bus error, 2 cache error and 3 machine check.
- R9: When the hold flag is 0 and no other event occurs in the cycle, the lowest pending or incoming error fires. `imp_fire` pulses, and `imp_code` is 6, 7, 30 or 24 for bits 0 to 3 respectively. That error's pending bit clears, and one error fires per cycle. In debug mode a fired error is a debug-mode exception: it redirects to the debug vector, records its code, loads `ret_pc` and sets the hold flag again.
- R10: In debug mode a write with `reg_sel`=0 changes only the bypass bit (18) and the hold flag (19). A write with `reg_sel`=1 loads `ret_pc`. A redirect event in the same cycle takes precedence over the write.
- R11: Outside debug mode, writes are ignored, a status read shows only the mode bit and the version, and a read with `reg_sel`=1 returns 0.
- R12: In debug mode, with the window present, addresses 0xFF200000 to 0xFF2FFFFF raise `seg_probe` and addresses 0xFF300000 to 0xFF3FFFFF raise `seg_regs`. Other addresses, and any address outside debug mode, raise neither output.
- R13: With the bypass bit set, loads and stores (`acc_is_ls`=1) are not decoded, but instruction fetches still are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Soft reset, leaves debug mode |
| dbg_src | input | 6 | Debug exception requests, bit order per R3 |
| exc_pc | input | AW | PC of the excepting instruction |
| core_halt | input | 1 | Core clock-halted state |
| core_doze | input | 1 | Core low-power state |
| exc_valid | input | 1 | Ordinary exception event |
| exc_code | input | 5 | Code of that exception |
| imp_err | input | 4 | Imprecise error reports, order per R8 |
| deret | input | 1 | Return-from-debug instruction |
| reg_sel | input | 1 | 0 status word, 1 return PC |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data |
| acc_addr | input | AW | Address to decode |
| acc_is_ls | input | 1 | 1 load or store, 0 fetch |
| dbg_mode | output | 1 | Core is in debug mode |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | AW | Redirect target |
| ret_pc | output | AW | Saved return PC |
| imp_fire | output | 1 | An imprecise error is delivered |
| imp_code | output | 5 | Code of the delivered error |
| seg_probe | output | 1 | Address hits probe memory |
| seg_regs | output | 1 | Address hits debug registers |

## Verification
The bound checker watches, on every cycle, that debug mode is entered only after a source request and left only after a return or a soft reset. It also checks that each entry sets the hold flag, that the recorded cause is never more than one-hot, that no error fires while held, that the two segment outputs are exclusive and appear only in debug mode, and that the return PC stays fixed when it is written outside debug mode. The bench scenarios show the values that the properties cannot: the source priority across all 63 request patterns, the codes and order in which every combination of held errors drains inside and outside debug mode, the field contents after each kind of exception, and the segment decode at every window edge under each mode and bypass setting.

// File: rtl/dbg_ctl_pkg.sv
// Shared constants for the debug mode control unit: source indices,
// status-word field positions and exception codes.
package dbg_ctl_pkg;

    localparam int NSRC   = 6;
    localparam int NIMP   = 4;
    localparam int CODE_W = 5;
    localparam int VER_W  = 3;

    // Debug source bit indices; the lowest index has priority on entry.
    localparam int SRC_SSTEP  = 0;
    localparam int SRC_DINT   = 1;
    localparam int SRC_IBRK   = 2;
    localparam int SRC_SWBRK  = 3;
    localparam int SRC_DSTORE = 4;
    localparam int SRC_DLOAD  = 5;

    // Status word field positions.
    localparam int F_MODE   = 0;
    localparam int F_VER    = 1;
    localparam int F_CAUSE  = 4;
    localparam int F_CODE   = 10;
    localparam int F_HALT   = 15;
    localparam int F_DOZE   = 16;
    localparam int F_NOSEG  = 17;
    localparam int F_BYPASS = 18;
    localparam int F_HOLD   = 19;
    localparam int F_PEND   = 20;
    localparam int WORD_W   = 32;

    localparam logic [CODE_W-1:0] CODE_SWBRK = 5'd9;

    // Exception code reported for each imprecise error source.
    function automatic logic [CODE_W-1:0] imp_code_of(input int idx);
        case (idx)
            0:       return 5'd6;
            1:       return 5'd7;
            2:       return 5'd30;
            3:       return 5'd24;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_src_arb.sv
// Fixed-priority pick among debug exception sources.
// Assumes bit 0 is the most urgent; grant is one-hot or zero.
module dbg_src_arb #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    // Keep only the lowest-numbered asserted request.
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/dbg_imp_defer.sv
// Holds imprecise error reports while the hold input is high and
// delivers them one per cycle, lowest index first, once it drops.
// Assumes hold already covers every cycle with a competing event.
module dbg_imp_defer
    import dbg_ctl_pkg::*;
#(
    parameter int N = NIMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              hold,
    input  logic [N-1:0]      err,
    output logic [N-1:0]      pend,
    output logic              fire,
    output logic [CODE_W-1:0] code
);

    logic [N-1:0] pend_q, pend_d, avail, pick;
    int           pick_idx;

    // Merge new reports with held ones and select the next to deliver.
    always_comb begin
        avail    = pend_q | err;
        pick     = '0;
        pick_idx = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (avail[i]) begin
                pick     = '0;
                pick[i]  = 1'b1;
                pick_idx = i;
            end
        end
        fire   = !hold && (|avail);
        code   = fire ? imp_code_of(pick_idx) : '0;
        pend_d = clr ? '0 : (fire ? (avail & ~pick) : avail);
    end

    // Pending state register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

endmodule

// File: rtl/dbg_seg_dec.sv
// Decodes the debug address window: lower half probe memory, upper
// half debug registers. Active only in debug mode with the window present;
// the bypass bit removes loads and stores but not fetches.
module dbg_seg_dec #(
    parameter int             AW       = 32,
    parameter int             SEG_LOG2 = 21,
    parameter logic [AW-1:0]  SEG_BASE = 32'hFF20_0000
) (
    input  logic [AW-1:0] addr,
    input  logic          is_ls,
    input  logic          in_dm,
    input  logic          bypass,
    input  logic          absent,
    output logic          probe,
    output logic          regs
);

    logic hit, en;

    // Window match on the upper address bits, then split by the half bit.
    always_comb begin
        hit   = (addr[AW-1:SEG_LOG2] == SEG_BASE[AW-1:SEG_LOG2]);
        en    = in_dm && !absent && !(bypass && is_ls) && hit;
        probe = en && !addr[SEG_LOG2-1];
        regs  = en &&  addr[SEG_LOG2-1];
    end

endmodule

// File: rtl/dbg_mode_ctl.sv
// Debug mode control unit top: mode flag, status word, return PC,
// redirect selection, imprecise-error deferral and segment decode.
// Assumes all event inputs are single-cycle and qualified by the core.
module dbg_mode_ctl
    import dbg_ctl_pkg::*;
#(
    parameter int               AW       = 32,
    parameter logic [AW-1:0]    DBG_VEC  = 32'hBFC0_0480,
    parameter logic [VER_W-1:0] VERSION  = 3'd2,
    parameter logic             NO_SEG   = 1'b0,
    parameter int               SEG_LOG2 = 21,
    parameter logic [AW-1:0]    SEG_BASE = 32'hFF20_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [NSRC-1:0]   dbg_src,
    input  logic [AW-1:0]     exc_pc,
    input  logic              core_halt,
    input  logic              core_doze,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [NIMP-1:0]   imp_err,
    input  logic              deret,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic [AW-1:0]     acc_addr,
    input  logic              acc_is_ls,
    output logic              dbg_mode,
    output logic              redir_valid,
    output logic [AW-1:0]     redir_pc,
    output logic [AW-1:0]     ret_pc,
    output logic              imp_fire,
    output logic [CODE_W-1:0] imp_code,
    output logic              seg_probe,
    output logic              seg_regs
);

    localparam logic [NSRC-1:0] SWBRK_BIT = NSRC'(1) << SRC_SWBRK;

    logic              dm_q, halt_q, doze_q, bypass_q, hold_q;
    logic [AW-1:0]     depc_q;
    logic [NSRC-1:0]   cause_q;
    logic [CODE_W-1:0] code_q;

    logic [NSRC-1:0]   grant;
    logic              src_any;
    logic [NIMP-1:0]   pend;
    logic              enter, dm_sw, dm_imp, dm_exc, ret, hold_imp, wr_ok;
    logic [CODE_W-1:0] dm_code;
    logic [NSRC-1:0]   dm_cause;
    logic [WORD_W-1:0] word;

    dbg_src_arb #(.N(NSRC)) u_arb (
        .req   (dbg_src),
        .grant (grant),
        .any   (src_any)
    );

    dbg_imp_defer #(.N(NIMP)) u_imp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .hold  (hold_imp),
        .err   (imp_err),
        .pend  (pend),
        .fire  (imp_fire),
        .code  (imp_code)
    );

    dbg_seg_dec #(.AW(AW), .SEG_LOG2(SEG_LOG2), .SEG_BASE(SEG_BASE)) u_seg (
        .addr   (acc_addr),
        .is_ls  (acc_is_ls),
        .in_dm  (dm_q),
        .bypass (bypass_q),
        .absent (NO_SEG),
        .probe  (seg_probe),
        .regs   (seg_regs)
    );

    // Classify this cycle's event by priority: soft reset, entry, debug-mode exception, return.
    always_comb begin
        enter    = !dm_q && src_any && !soft_rst;
        dm_sw    = dm_q && !soft_rst && (exc_valid || dbg_src[SRC_SWBRK]);
        ret      = dm_q && !soft_rst && deret && !dm_sw;
        hold_imp = hold_q || soft_rst || enter || dm_sw || ret;
        dm_imp   = dm_q && imp_fire;
        dm_exc   = dm_sw || dm_imp;
        wr_ok    = reg_we && dm_q && !soft_rst && !dm_exc && !ret;
    end

    // Code and cause recorded for an exception taken inside debug mode.
    always_comb begin
        if (dm_sw) begin
            dm_code  = exc_valid ? exc_code : CODE_SWBRK;
            dm_cause = exc_valid ? '0 : SWBRK_BIT;
        end else begin
            dm_code  = imp_code;
            dm_cause = '0;
        end
    end

    // Fetch redirect target: saved PC on return, debug vector otherwise.
    always_comb begin
        redir_valid = enter || dm_exc || ret;
        redir_pc    = ret ? depc_q : DBG_VEC;
    end

    // Mode, status fields and return PC update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_q     <= 1'b0;
            depc_q   <= '0;
            cause_q  <= '0;
            code_q   <= '0;
            halt_q   <= 1'b0;
            doze_q   <= 1'b0;
            bypass_q <= 1'b0;
            hold_q   <= 1'b0;
        end else if (soft_rst) begin
            dm_q     <= 1'b0;
            bypass_q <= 1'b0;
            hold_q   <= 1'b0;
        end else if (enter) begin
            dm_q    <= 1'b1;
            depc_q  <= exc_pc;
            cause_q <= grant;
            code_q  <= '0;
            halt_q  <= core_halt;
            doze_q  <= core_doze;
            hold_q  <= 1'b1;
        end else if (dm_exc) begin
            depc_q  <= exc_pc;
            cause_q <= dm_cause;
            code_q  <= dm_code;
            halt_q  <= 1'b0;
            doze_q  <= 1'b0;
            hold_q  <= 1'b1;
        end else if (ret) begin
            dm_q   <= 1'b0;
            hold_q <= 1'b0;
        end else if (wr_ok) begin
            if (reg_sel) begin
                depc_q <= reg_wdata;
            end else begin
                bypass_q <= reg_wdata[F_BYPASS];
                hold_q   <= reg_wdata[F_HOLD];
            end
        end
    end

    // Assemble the status word; only mode and version show outside debug mode.
    always_comb begin
        word                      = '0;
        word[F_MODE]              = dm_q;
        word[F_VER +: VER_W]      = VERSION;
        if (dm_q) begin
            word[F_CAUSE +: NSRC]   = cause_q;
            word[F_CODE +: CODE_W]  = code_q;
            word[F_HALT]            = halt_q;
            word[F_DOZE]            = doze_q;
            word[F_NOSEG]           = NO_SEG;
            word[F_BYPASS]          = bypass_q;
            word[F_HOLD]            = hold_q;
            word[F_PEND +: NIMP]    = pend;
        end
    end

    // Read mux; the return PC reads as zero outside debug mode.
    always_comb begin
        if (reg_sel) reg_rdata = dm_q ? depc_q : '0;
        else         reg_rdata = AW'(word);
    end

    assign dbg_mode = dm_q;
    assign ret_pc   = depc_q;

endmodule

// File: rtl/dbg_mode_ctl_chk.sv
// Cycle-level properties of the debug mode control unit, bound to the top.
module dbg_mode_ctl_chk
    import dbg_ctl_pkg::*;
#(
    parameter int AW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst,
    input logic [NSRC-1:0] dbg_src,
    input logic            exc_valid,
    input logic            deret,
    input logic            reg_we,
    input logic            dbg_mode,
    input logic            redir_valid,
    input logic [AW-1:0]   redir_pc,
    input logic [AW-1:0]   ret_pc,
    input logic            imp_fire,
    input logic            seg_probe,
    input logic            seg_regs,
    input logic            hold,
    input logic [NSRC-1:0] cause
);

    // R2
    enter_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode) |-> $past(|dbg_src));

    // R6
    exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dbg_mode) |-> $past(deret || soft_rst));

    // R6
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_mode && deret && !exc_valid && !dbg_src[SRC_SWBRK] && !soft_rst)
            |-> (redir_valid && redir_pc == ret_pc));

    // R3
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause));

    // R8
    hold_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_mode) |-> hold);

    // R9
    no_fire_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imp_fire |-> !hold);

    // R12
    seg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seg_probe, seg_regs}));

    // R12
    seg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_probe || seg_regs) |-> dbg_mode);

    // R11
    nondm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && reg_we && dbg_src == '0 && !soft_rst) |=> $stable(ret_pc));

endmodule

bind dbg_mode_ctl dbg_mode_ctl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .dbg_src     (dbg_src),
    .exc_valid   (exc_valid),
    .deret       (deret),
    .reg_we      (reg_we),
    .dbg_mode    (dbg_mode),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .ret_pc      (ret_pc),
    .imp_fire    (imp_fire),
    .seg_probe   (seg_probe),
    .seg_regs    (seg_regs),
    .hold        (hold_q),
    .cause       (cause_q)
);

// File: tb/dbg_mode_ctl_bench.sv
// Self-checking bench: sweeps source patterns, error combinations,
// register access rules and the address window edges.
module dbg_mode_ctl_bench;

    localparam logic [31:0] VEC = 32'hBFC0_0480;

    logic        clk = 1'b0;
    logic        rst_n, soft_rst, core_halt, core_doze, exc_valid, deret;
    logic        reg_sel, reg_we, acc_is_ls;
    logic [5:0]  dbg_src;
    logic [31:0] exc_pc, reg_wdata, reg_rdata, acc_addr, redir_pc, ret_pc;
    logic [4:0]  exc_code, imp_code;
    logic [3:0]  imp_err;
    logic        dbg_mode, redir_valid, imp_fire, seg_probe, seg_regs;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    dbg_mode_ctl u_dbg_mode_ctl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dbg_src(dbg_src),
        .exc_pc(exc_pc), .core_halt(core_halt), .core_doze(core_doze),
        .exc_valid(exc_valid), .exc_code(exc_code), .imp_err(imp_err),
        .deret(deret), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
        .acc_is_ls(acc_is_ls), .dbg_mode(dbg_mode), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .ret_pc(ret_pc), .imp_fire(imp_fire),
        .imp_code(imp_code), .seg_probe(seg_probe), .seg_regs(seg_regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input logic dm, input logic [5:0] cause,
        input logic [4:0] code, input logic halt, input logic doze,
        input logic byp, input logic hold, input logic [3:0] pend);
        return {8'b0, pend, hold, byp, 1'b0, doze, halt, code, cause, 3'd2, dm};
    endfunction

    function automatic logic [4:0] ecode(input int i);
        case (i)
            0: return 5'd6;
            1: return 5'd7;
            2: return 5'd30;
            default: return 5'd24;
        endcase
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic go_dm(input logic [5:0] s, input logic [31:0] pc);
        dbg_src = s;
        exc_pc  = pc;
        tick();
        dbg_src = '0;
        #1;
    endtask

    task automatic leave;
        deret = 1'b1;
        tick();
        deret = 1'b0;
        #1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel   = sel;
        reg_we    = 1'b1;
        reg_wdata = d;
        tick();
        reg_we  = 1'b0;
        reg_sel = 1'b0;
        #1;
    endtask

    task automatic seg_sweep(input logic dm, input logic byp);
        logic [31:0] addrs [7];
        addrs = '{32'hFF1F_FFFF, 32'hFF20_0000, 32'hFF2F_FFFF, 32'hFF30_0000,
                  32'hFF3F_FFFF, 32'hFF40_0000, 32'h7F20_0000};
        for (int a = 0; a < 7; a++) begin
            for (int ls = 0; ls < 2; ls++) begin
                logic en;
                acc_addr  = addrs[a];
                acc_is_ls = ls[0];
                #1;
                en = dm && !(byp && ls[0]) &&
                     addrs[a] >= 32'hFF20_0000 && addrs[a] <= 32'hFF3F_FFFF;
                // R12 R13
                chk("R12/R13 probe", {31'b0, seg_probe}, {31'b0, en && addrs[a] < 32'hFF30_0000});
                chk("R12/R13 regs", {31'b0, seg_regs}, {31'b0, en && addrs[a] >= 32'hFF30_0000});
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; soft_rst = 0; core_halt = 0; core_doze = 0; exc_valid = 0;
        deret = 0; reg_sel = 0; reg_we = 0; acc_is_ls = 0; dbg_src = '0;
        exc_pc = '0; reg_wdata = '0; acc_addr = '0; exc_code = '0; imp_err = '0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 mode", {31'b0, dbg_mode}, 0);
        chk("R1 word", reg_rdata, mk(0, 0, 0, 0, 0, 0, 0, 0));
        chk("R1 retpc", ret_pc, 0);
        chk("R1 redir", {31'b0, redir_valid}, 0);
        chk("R1 fire", {31'b0, imp_fire}, 0);
        acc_addr = 32'hFF20_0000;
        #1;
        chk("R1 seg", {30'b0, seg_probe, seg_regs}, 0);

        // R2 R3 R4: every source pattern
        for (int s = 1; s < 64; s++) begin
            int lo;
            logic [5:0] sv;
            sv = 6'(s);
            lo = 0;
            for (int b = 5; b >= 0; b--) if (sv[b]) lo = b;
            core_halt = sv[1];
            core_doze = sv[2];
            dbg_src   = sv;
            exc_pc    = 32'h8000_0000 + 32'(s) * 4;
            #1;
            chk("R2 redir", {31'b0, redir_valid}, 1);
            chk("R2 vector", redir_pc, VEC);
            tick();
            dbg_src = '0; core_halt = 0; core_doze = 0;
            #1;
            chk("R2 mode", {31'b0, dbg_mode}, 1);
            chk("R2 retpc", ret_pc, 32'h8000_0000 + 32'(s) * 4);
            chk("R3/R4 word", reg_rdata, mk(1, 6'(1 << lo), 0, sv[1], sv[2], 0, 1, 0));
            deret = 1;
            #1;
            chk("R6 target", redir_pc, 32'h8000_0000 + 32'(s) * 4);
            tick();
            deret = 0;
            #1;
            chk("R6 mode", {31'b0, dbg_mode}, 0);
            chk("R6 word", reg_rdata, mk(0, 0, 0, 0, 0, 0, 0, 0));
        end

        // R5 ignored sources and exceptions in debug mode
        go_dm(6'b000001, 32'h100);
        dbg_src = 6'b110111;
        #1;
        chk("R5 ignore redir", {31'b0, redir_valid}, 0);
        tick();
        dbg_src = '0;
        #1;
        chk("R5 ignore word", reg_rdata, mk(1, 1, 0, 0, 0, 0, 1, 0));
        chk("R5 ignore retpc", ret_pc, 32'h100);
        exc_valid = 1; exc_code = 5'd12; dbg_src = 6'b001000; exc_pc = 32'h3000; core_halt = 1;
        #1;
        chk("R5 exc redir", {26'b0, redir_valid, 5'b0} | redir_pc, VEC | 32'h20);
        tick();
        exc_valid = 0; dbg_src = '0; core_halt = 0;
        #1;
        chk("R5 exc word", reg_rdata, mk(1, 0, 12, 0, 0, 0, 1, 0));
        chk("R5 exc retpc", ret_pc, 32'h3000);
        go_dm(6'b001000, 32'h3004);
        chk("R5 swbrk word", reg_rdata, mk(1, 6'b001000, 9, 0, 0, 0, 1, 0));
        chk("R5 mode", {31'b0, dbg_mode}, 1);

        // R6 exception beats return; return outside debug mode ignored
        deret = 1; exc_valid = 1; exc_code = 5'd4; exc_pc = 32'h3008;
        #1;
        chk("R6 prio target", redir_pc, VEC);
        tick();
        deret = 0; exc_valid = 0;
        #1;
        chk("R6 prio mode", {31'b0, dbg_mode}, 1);
        chk("R6 prio word", reg_rdata, mk(1, 0, 4, 0, 0, 0, 1, 0));
        leave();
        deret = 1;
        #1;
        chk("R6 outside redir", {31'b0, redir_valid}, 0);
        tick();
        deret = 0;
        #1;
        chk("R6 outside mode", {31'b0, dbg_mode}, 0);

        // R10 register writes in debug mode
        go_dm(6'b000001, 32'h200);
        wr(0, 32'hFFFF_FFFF);
        chk("R10 word", reg_rdata, mk(1, 1, 0, 0, 0, 1, 1, 0));
        wr(1, 32'h1234_5678);
        chk("R10 retpc", ret_pc, 32'h1234_5678);
        reg_sel = 1;
        #1;
        chk("R10 read retpc", reg_rdata, 32'h1234_5678);
        reg_sel = 0;
        reg_we = 1; reg_wdata = 32'h0; exc_valid = 1; exc_code = 5'd2; exc_pc = 32'h204;
        tick();
        reg_we = 0; exc_valid = 0;
        #1;
        chk("R10 event wins", reg_rdata, mk(1, 0, 2, 0, 0, 1, 1, 0));
        deret = 1;
        #1;
        chk("R10 return to written", redir_pc, 32'h204);
        tick();
        deret = 0;
        #1;

        // R7 soft reset
        go_dm(6'b000010, 32'h300);
        wr(0, 32'h000C_0000);
        imp_err = 4'b0100;
        tick();
        imp_err = 0;
        soft_rst = 1;
        #1;
        chk("R7 redir", {31'b0, redir_valid}, 0);
        tick();
        soft_rst = 0;
        #1;
        chk("R7 mode", {31'b0, dbg_mode}, 0);
        chk("R7 fire", {31'b0, imp_fire}, 0);
        go_dm(6'b000010, 32'h304);
        chk("R7 cleared", reg_rdata, mk(1, 2, 0, 0, 0, 0, 1, 0));
        leave();

        // R11 access outside debug mode
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'h0000_DEAD);
        chk("R11 word", reg_rdata, mk(0, 0, 0, 0, 0, 0, 0, 0));
        chk("R11 retpc kept", ret_pc, 32'h304);
        reg_sel = 1;
        #1;
        chk("R11 retpc read", reg_rdata, 0);
        reg_sel = 0;
        go_dm(6'b000100, 32'h400);
        chk("R11 no bypass", reg_rdata, mk(1, 4, 0, 0, 0, 0, 1, 0));
        leave();

        // R9 immediate delivery outside debug mode
        imp_err = 4'b1010;
        #1;
        chk("R9 fire a", {31'b0, imp_fire}, 1);
        chk("R9 code a", {27'b0, imp_code}, 7);
        chk("R9 no redir", {31'b0, redir_valid}, 0);
        tick();
        imp_err = 0;
        #1;
        chk("R9 code b", {26'b0, imp_fire, imp_code}, {26'b0, 1'b1, 5'd24});
        tick();
        chk("R9 drained", {31'b0, imp_fire}, 0);

        // R8 R9 every error combination held then released
        for (int p = 1; p < 16; p++) begin
            int lo;
            logic [3:0] pv;
            pv = 4'(p);
            lo = 0;
            for (int b = 3; b >= 0; b--) if (pv[b]) lo = b;
            go_dm(6'b000001, 32'h1000);
            imp_err = pv;
            #1;
            chk("R8 held", {31'b0, imp_fire}, 0);
            tick();
            imp_err = 0;
            #1;
            chk("R8 pending", reg_rdata, mk(1, 1, 0, 0, 0, 0, 1, pv));
            wr(0, 32'h0);
            exc_pc = 32'h2000 + 32'(p);
            #1;
            chk("R9 dm fire", {26'b0, imp_fire, imp_code}, {26'b0, 1'b1, ecode(lo)});
            chk("R9 dm redir", {31'b0, redir_valid}, 1);
            chk("R9 dm vector", redir_pc, VEC);
            tick();
            #1;
            chk("R9 dm word", reg_rdata, mk(1, 0, ecode(lo), 0, 0, 0, 1, pv & ~(4'(1) << lo)));
            chk("R9 dm retpc", ret_pc, 32'h2000 + 32'(p));
            leave();
            for (int i = lo + 1; i < 4; i++) begin
                if (pv[i]) begin
                    chk("R9 drain", {25'b0, dbg_mode, imp_fire, imp_code}, {25'b0, 1'b0, 1'b1, ecode(i)});
                    tick();
                end
            end
            chk("R9 empty", {31'b0, imp_fire}, 0);
        end

        // R12 R13 window decode
        seg_sweep(0, 0);
        go_dm(6'b000001, 32'h500);
        seg_sweep(1, 0);
        wr(0, 32'h0004_0000);
        seg_sweep(1, 1);
        leave();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule